// File: doc/BRIEF.md
# Page-Mode Burst ROM Bus Controller

This block connects an internal host to an external page-mode ROM or flash part. The host hands over one request at a time: a byte address, a size code, a read/write flag and write data. The controller then drives chip select, output enable, write enable, a bus-start strobe and the address pins. When a read is wider than the external data bus, the controller splits it into a burst of beats. The output enable stays low for the whole burst, and only the address moves from beat to beat.

Two wait fields are held in programmable registers. The first beat uses a 4-bit count and can also be stretched by an external wait input. Every later beat uses a 2-bit count, and the wait input has no effect on it. Single reads and all writes take one beat with the same timing as ordinary static memory. Each captured word goes back to the host with a valid pulse. A done pulse marks the end of every transaction.

Top module: `burst_rom_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and bus-start are high (inactive). `req_ready_o` is high, and `rsp_valid_o` and `rsp_done_o` are low. The first-beat wait field resets to 15 and the later-beat wait field resets to 3.
- R2: The size code s means 2^s bytes. A read with 2^s greater than the bus width in bytes is split into 2^s / bus-bytes beats; with the default 32-bit bus, size codes 3 and 4 give 2 and 4 beats. A read with 2^s no greater than the bus width, and any write, takes one beat. Beat b drives the address request address + b × bus-bytes.
- R3: The first beat lasts (first-beat wait + 1) cycles. If the external wait input is high on a cycle once the count has expired, the beat is extended by one more cycle.
- R4: Each later beat lasts exactly (later-beat wait + 1) cycles. The external wait input has no effect on later beats.
- R5: Bus-start is low for every cycle of the first beat and high for every later beat.
- R6: Chip select is low from the first cycle of the first beat through the last cycle of the last beat. For reads, output enable is low over the same span with no gap between beats. Both return high on the cycle after the last beat.
- R7: The address output changes on the falling clock edge. At the rising edge that starts a new beat, the pins still show the previous beat's address.
- R8: One cycle after each read beat ends, `rsp_valid_o` is high and `rsp_data_o` holds the bus data sampled at the last edge of that beat. `rsp_done_o` pulses on the cycle after the final beat, for reads and for writes.
- R9: A write drives write enable low for its single beat, with the request's write data on `mem_wdata_o`. Output enable stays high during a write, and bus-start still marks the beat.
- R10: A pulse on `cfg_we_i` loads both wait fields. `req_ready_o` is low from the cycle after a request is accepted until the cycle after its last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads both wait fields |
| cfg_first_wait_i | input | FW_W | First-beat wait count |
| cfg_burst_wait_i | input | BW_W | Later-beat wait count |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | SIZE_W | Log2 of access size in bytes |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read word available |
| rsp_data_o | output | DATA_W | Read word |
| rsp_done_o | output | 1 | Transaction finished |
| mem_addr_o | output | ADDR_W | External address, updated on falling edge |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable (read strobe), active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_start_no | output | 1 | Bus-start strobe, active low |
| mem_wait_i | input | 1 | External wait, first beat only |
| mem_rdata_i | input | DATA_W | External read data |
| mem_wdata_o | output | DATA_W | External write data |

## Verification
Every combination of first-beat wait (0–15) and later-beat wait (0–3) is run with size codes 0 to 4, as reads and as writes, with and without two cycles of external wait. The size sweep separates single beats from 2- and 4-beat bursts and checks the beat count and the address step. Holding the wait input high through every later beat separates a first-beat-only wait from one applied on all beats. The different wait counts show whether each beat length comes from the right field. A probe at the rising edge confirms the address is still stable there. The returned data, which depends on the address, shows whether each capture took the current beat's address.

// File: rtl/burst_rom_pkg.sv
package burst_rom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_NEXT  = 2'd2
  } brc_state_e;
endpackage

// File: rtl/brc_wait_cfg.sv
module brc_wait_cfg #(
  parameter int          FW_W   = 4,
  parameter int          BW_W   = 2,
  parameter int unsigned FW_RST = 15,
  parameter int unsigned BW_RST = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [FW_W-1:0] first_wait_i,
  input  logic [BW_W-1:0] burst_wait_i,
  output logic [FW_W-1:0] first_wait_o,
  output logic [BW_W-1:0] burst_wait_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_wait_o <= FW_W'(FW_RST);
      burst_wait_o <= BW_W'(BW_RST);
    end else if (we_i) begin
      first_wait_o <= first_wait_i;
      burst_wait_o <= burst_wait_i;
    end
  end
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import burst_rom_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int FW_W   = 4,
  parameter int BW_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FW_W-1:0]   first_wait_i,
  input  logic [BW_W-1:0]   burst_wait_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              mem_wait_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output brc_state_e        state_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_done_o
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam int BUS_LG    = $clog2(BUS_BYTES);
  localparam int REM_W     = 2 ** SIZE_W;
  localparam int CNT_W     = (FW_W > BW_W) ? FW_W : BW_W;

  brc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REM_W-1:0]  rem_q;
  logic [REM_W-1:0]  beats_m1;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              beat_end;

  // beats - 1 for the incoming request; writes and narrow reads are single
  always_comb begin
    if (req_write_i || req_size_i <= SIZE_W'(BUS_LG)) beats_m1 = '0;
    else beats_m1 = (REM_W'(1) << (req_size_i - SIZE_W'(BUS_LG))) - REM_W'(1);
  end

  // external wait only stretches the first beat
  always_comb begin
    unique case (state_q)
      ST_FIRST: beat_end = (cnt_q == '0) && !mem_wait_i;
      ST_NEXT:  beat_end = (cnt_q == '0);
      default:  beat_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rem_q       <= '0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_done_o  <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_done_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q <= ST_FIRST;
            cnt_q   <= CNT_W'(first_wait_i);
            rem_q   <= beats_m1;
            wr_q    <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
          end
        end
        ST_FIRST, ST_NEXT: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          if (beat_end) begin
            if (!wr_q) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= mem_rdata_i;
            end
            if (rem_q == '0) begin
              state_q    <= ST_IDLE;
              rsp_done_o <= 1'b1;
            end else begin
              state_q <= ST_NEXT;
              rem_q   <= rem_q - REM_W'(1);
              cnt_q   <= CNT_W'(burst_wait_i);
              addr_q  <= addr_q + ADDR_W'(BUS_BYTES);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign state_o     = state_q;
  assign wr_o        = wr_q;
  assign beat_addr_o = addr_q;
  assign wdata_o     = wdata_q;
endmodule

// File: rtl/brc_pins.sv
module brc_pins
  import burst_rom_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  brc_state_e        state_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_start_no
);
  logic active;

  // address launched half a cycle after the beat register moves
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_addr_o <= '0;
    else         mem_addr_o <= beat_addr_i;
  end

  assign active       = (state_i != ST_IDLE);
  assign mem_cs_no    = !active;
  assign mem_oe_no    = !(active && !wr_i);
  assign mem_we_no    = !(active && wr_i);
  assign mem_start_no = !(state_i == ST_FIRST);
endmodule

// File: rtl/burst_rom_ctrl.sv
module burst_rom_ctrl
  import burst_rom_pkg::*;
#(
  parameter int          ADDR_W = 26,
  parameter int          DATA_W = 32,
  parameter int          SIZE_W = 3,
  parameter int          FW_W   = 4,
  parameter int          BW_W   = 2,
  parameter int unsigned FW_RST = 15,
  parameter int unsigned BW_RST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [FW_W-1:0]   cfg_first_wait_i,
  input  logic [BW_W-1:0]   cfg_burst_wait_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_start_no,
  input  logic              mem_wait_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [FW_W-1:0]   first_wait;
  logic [BW_W-1:0]   burst_wait;
  brc_state_e        state;
  logic              wr;
  logic [ADDR_W-1:0] beat_addr;

  brc_wait_cfg #(
    .FW_W(FW_W), .BW_W(BW_W), .FW_RST(FW_RST), .BW_RST(BW_RST)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .first_wait_i (cfg_first_wait_i),
    .burst_wait_i (cfg_burst_wait_i),
    .first_wait_o (first_wait),
    .burst_wait_o (burst_wait)
  );

  brc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .FW_W(FW_W), .BW_W(BW_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .first_wait_i (first_wait),
    .burst_wait_i (burst_wait),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_size_i   (req_size_i),
    .req_write_i  (req_write_i),
    .req_wdata_i  (req_wdata_i),
    .mem_wait_i   (mem_wait_i),
    .mem_rdata_i  (mem_rdata_i),
    .state_o      (state),
    .wr_o         (wr),
    .beat_addr_o  (beat_addr),
    .wdata_o      (mem_wdata_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o),
    .rsp_done_o   (rsp_done_o)
  );

  brc_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .wr_i         (wr),
    .beat_addr_i  (beat_addr),
    .mem_addr_o   (mem_addr_o),
    .mem_cs_no    (mem_cs_no),
    .mem_oe_no    (mem_oe_no),
    .mem_we_no    (mem_we_no),
    .mem_start_no (mem_start_no)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic rsp_done_o,
  input logic mem_cs_no,
  input logic mem_oe_no,
  input logic mem_we_no,
  input logic mem_start_no
);
  AST_START_FIRST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && mem_start_no) |=> (mem_cs_no || mem_start_no)); // R5
  AST_START_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_start_no |-> !mem_cs_no); // R5
  AST_OE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && !mem_oe_no) |=> (mem_cs_no || !mem_oe_no)); // R6
  AST_RELEASE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_no) |-> mem_oe_no); // R6
  AST_DONE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $rose(mem_cs_no)); // R8
  AST_VALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_oe_no)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)); // R9
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_cs_no); // R10
endmodule

bind burst_rom_ctrl brc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_done_o   (rsp_done_o),
  .mem_cs_no    (mem_cs_no),
  .mem_oe_no    (mem_oe_no),
  .mem_we_no    (mem_we_no),
  .mem_start_no (mem_start_no)
);

// File: tb/burst_rom_ctrl_test.sv
`timescale 1ns/100ps
module burst_rom_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_fw = '0;
  logic [1:0]  cfg_bw = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_done;
  logic [31:0] rsp_data;
  logic [25:0] mem_addr;
  logic        cs_n, oe_n, we_n, start_n;
  logic        mem_wait = 1'b0;
  logic [31:0] mem_rdata, mem_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  // ROM model: data is a function of the address
  assign mem_rdata = {~mem_addr[15:0], mem_addr[15:0]};

  burst_rom_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_first_wait_i(cfg_fw), .cfg_burst_wait_i(cfg_bw),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_done_o(rsp_done),
    .mem_addr_o(mem_addr), .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_start_no(start_n), .mem_wait_i(mem_wait), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] rom_word(logic [25:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic run_txn(bit do_cfg, int fw, int bw, int sz, bit wr, int st, logic [25:0] base);
    int nb, l0, lb, total, b, rel;
    logic [31:0] wd;
    nb = (!wr && sz > 2) ? (1 << (sz - 2)) : 1;
    l0 = fw + st + 1;
    lb = bw + 1;
    total = l0 + (nb - 1) * lb;
    wd = {base[15:0] ^ 16'h5a5a, 6'd0, base};
    if (do_cfg) begin
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_fw = 4'(fw); cfg_bw = 2'(bw);
      @(posedge clk); #1;
      cfg_we = 1'b0;
    end else begin
      @(posedge clk); #1;
    end
    req_valid = 1'b1; req_addr = base; req_size = 3'(sz); req_write = wr; req_wdata = wd;
    @(posedge clk);
    for (int c = 1; c <= total + 1; c++) begin
      if (c > 1) @(posedge clk);
      #1;
      req_valid = 1'b0;
      // R7: at the rising edge the pins still hold the previous cycle's beat address
      if (c > 1 && c <= total) begin
        b = (c - 1 <= l0) ? 0 : 1 + (c - 1 - l0 - 1) / lb;
        chk("R7 addr at rising edge", mem_addr, base + 26'(4 * b));
      end
      if (c <= l0) mem_wait = (c <= fw + st);
      else mem_wait = (c <= total);  // R4: wait held high across later beats
      #3;
      if (c <= total) begin
        b = (c <= l0) ? 0 : 1 + (c - l0 - 1) / lb;
        chk("R6 cs low in transfer", cs_n, 0);
        chk("R5 start on first beat", start_n, (c <= l0) ? 0 : 1);
        chk("R6/R9 oe", oe_n, wr ? 1 : 0);
        chk("R9 we", we_n, wr ? 0 : 1);
        chk("R10 ready busy", req_ready, 0);
        chk("R2 beat address", mem_addr, base + 26'(4 * b));
        if (wr) chk("R9 write data", mem_wdata, wd);
      end else begin
        chk("R6 cs release", cs_n, 1);
        chk("R6 oe release", oe_n, 1);
        chk("R9 we release", we_n, 1);
        chk("R5 start release", start_n, 1);
        chk("R10 ready idle", req_ready, 1);
      end
      // R3/R4/R8: valid one cycle after each beat end
      rel = c - 1 - l0;
      if (!wr && rel >= 0 && (rel % lb) == 0 && (rel / lb) < nb) begin
        chk("R8 valid", rsp_valid, 1);
        chk("R8 data", rsp_data, rom_word(base + 26'(4 * (rel / lb))));
      end else begin
        chk("R8 no valid", rsp_valid, 0);
      end
      chk("R8 done", rsp_done, (c == total + 1) ? 1 : 0);
    end
    mem_wait = 1'b0;
  endtask

  initial begin
    int n;
    n = 0;
    #12 rst_n = 1'b1;
    @(posedge clk); #4;
    chk("R1 cs reset", cs_n, 1);
    chk("R1 oe reset", oe_n, 1);
    chk("R1 we reset", we_n, 1);
    chk("R1 start reset", start_n, 1);
    chk("R1 ready reset", req_ready, 1);
    chk("R1 valid reset", rsp_valid, 0);
    chk("R1 done reset", rsp_done, 0);
    // R1: reset wait values 15 / 3 used without any config write
    run_txn(1'b0, 15, 3, 4, 1'b0, 0, 26'h0000100);
    for (int fw = 0; fw < 16; fw++)
      for (int bw = 0; bw < 4; bw++)
        for (int sz = 0; sz < 5; sz++)
          for (int wr = 0; wr < 2; wr++)
            for (int st = 0; st < 3; st += 2) begin
              n++;
              run_txn(1'b1, fw, bw, sz, wr[0], st, 26'(32'h200 + n * 20));
            end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule